// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital controller of a 12-bit charge-balancing successive approximation converter. Every conversion is a frame of exactly 15 clock periods. Control changes only on the rising clock edge.

In periods 1 to 3 the input sample switch is closed and the comparator is auto-balanced. From period 4 on, the block drives a trial code to the capacitor switches. It tests one bit per period, from the most significant bit down to the least significant bit. Each tested bit is kept or cleared according to the 1-bit comparator decision. When period 15 ends, the resolved straight-binary code is loaded into an output register. That register holds the code through the whole next frame. At the same edge a data-ready flag is raised.

An active-low start request passes through a two-flop synchronizer. If the request is held low, the converter runs frame after frame. If no request is pending when a frame wraps, the sequencer halts in period 2. While halted, the input is still tracked and data-ready stays high. A later start request clears data-ready and moves the sequencer on to period 3. The result is read through two active-low group enables: one for the upper 8 bits and one for the lower 4 bits.

Top module: `sar_seq_top`

## Requirements
- R1: With start held low, a frame lasts exactly 15 clock periods, so data-ready rises every 15 cycles.
- R2: Track and balance are high in periods 1 to 3 and while parked in period 2. They are low in periods 4 to 15, which is 12 consecutive cycles per frame. While track is high the trial code is zero.
- R3: In period 4 the trial code is 12'h800, with only the most significant bit set. At the end of each trial period the tested bit takes the comparator value (1 keeps it) and the next lower bit is set for its trial.
- R4: The result is the straight-binary code found by the search. With an ideal comparator that is high when the input code is at or above the trial code, the result equals the input code for every value from 0 to 4095.
- R5: The output register changes only at the end of period 15. It holds its value through the following frame.
- R6: Data-ready rises at the same edge the new result is loaded, as the frame returns to period 1. During free-running conversion it is high for exactly one period.
- R7: start_n is active low and synchronized by two flops. It only acts in periods 1 and 2. A low pulse that lies entirely within periods 3 to 15 has no effect.
- R8: With no start pending, the sequencer parks in period 2 with track high and data-ready unchanged. A start request clears data-ready and advances to period 3. Data-ready then rises again 13 cycles later.
- R9: A low upper_en_n presents result bits 11 to 4 on dout_o[11:4], and a low lower_en_n presents bits 3 to 0 on dout_o[3:0]. A disabled group reads as zeros.
- R10: A synchronous active-high reset gives period 1 with track high, trial code zero, data-ready low and the result register zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Conversion request, active low, asynchronous |
| cmp_hi | input | 1 | Comparator decision, 1 keeps the tested bit |
| upper_en_n | input | 1 | Active-low enable for dout_o[11:4] |
| lower_en_n | input | 1 | Active-low enable for dout_o[3:0] |
| track_o | output | 1 | Sample switch closed (input tracked) |
| balance_o | output | 1 | Comparator auto-balance control |
| trial_o | output | 12 | Trial code to the capacitor DAC switches |
| ready_o | output | 1 | Data-ready flag |
| dout_o | output | 12 | Latched result, zero in disabled groups |

## Verification
Conversions are first run on the extreme codes 0, 4095, 1 and 4094 and on the half-scale neighbours 2048 and 2047. These tell apart errors in keeping the top bit and in resolving the last bit. They are followed by a seeded random sweep in free-running mode, which shows that frame length and result latching hold over many consecutive frames.

Single conversions started from the parked state check the 13-cycle restart latency and the parked behaviour. A start pulse is placed in the middle of a frame to show that it cannot re-arm the sequencer. All four enable combinations are applied to a known parked result to separate the two output groups.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_TRACK = 2'd0,
    PH_TRIAL = 2'd1
  } phase_e;

  // Phase of a frame period: periods 1..trk track, the rest run bit trials.
  function automatic phase_e f_phase(input int unsigned period, input int unsigned trk);
    return (period <= trk) ? PH_TRACK : PH_TRIAL;
  endfunction

  // Index of the bit under trial in a given period (last period tests bit 0).
  function automatic int unsigned f_trial_bit(input int unsigned period, input int unsigned frame_len);
    return frame_len - period;
  endfunction
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n_i,
  output logic req_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[STAGES-2:0], req_n_i};
  end

  assign req_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_pkg::*;
#(
  parameter int RES   = 12,
  parameter int TRACK = 3,
  localparam int FRAME = TRACK + RES,
  localparam int PW    = $clog2(FRAME + 1),
  localparam int IW    = $clog2(RES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req_i,
  output logic [PW-1:0] period_o,
  output logic          track_o,
  output logic          trial_act_o,
  output logic [IW-1:0] trial_idx_o,
  output logic          enter_hold_o,
  output logic          wrap_o,
  output logic          ready_o
);
  localparam logic [PW-1:0] P_FIRST = PW'(1);
  localparam logic [PW-1:0] P_PARK  = PW'(2);
  localparam logic [PW-1:0] P_TEND  = PW'(TRACK);
  localparam logic [PW-1:0] P_LAST  = PW'(FRAME);

  logic [PW-1:0] period_q;
  logic          armed_q;
  logic          ready_q;
  phase_e        phase;

  // named events for the assertions
  logic in_gate;
  logic hold_here;

  assign phase        = f_phase(int'(period_q), TRACK);
  assign in_gate      = (period_q == P_FIRST) || (period_q == P_PARK);
  assign hold_here    = (period_q == P_PARK) && !(armed_q || start_req_i);
  assign wrap_o       = (period_q == P_LAST);
  assign enter_hold_o = (period_q == P_TEND);
  assign trial_act_o  = (phase == PH_TRIAL);
  assign track_o      = (phase == PH_TRACK);
  assign trial_idx_o  = IW'(f_trial_bit(int'(period_q), FRAME));
  assign period_o     = period_q;
  assign ready_o      = ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= P_FIRST;
      armed_q  <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      if (wrap_o)          period_q <= P_FIRST;
      else if (!hold_here) period_q <= period_q + PW'(1);

      if ((period_q == P_FIRST) && start_req_i)      armed_q <= 1'b1;
      else if ((period_q == P_PARK) && !hold_here)   armed_q <= 1'b0;

      if (wrap_o)                      ready_q <= 1'b1;
      else if (in_gate && start_req_i) ready_q <= 1'b0;
    end
  end

  // R1: a frame always returns to period 1 after its last period
  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (period_q == P_FIRST));

  // R1: once bit trials begin they continue until the frame wraps
  assert_trials_run_R1: assert property (@(posedge clk) disable iff (rst)
    (trial_act_o && !wrap_o) |=> trial_act_o);

  // R8: with nothing pending the sequencer stays parked and ready holds
  assert_park_R8: assert property (@(posedge clk) disable iff (rst)
    hold_here |=> ((period_q == P_PARK) && (ready_q == $past(ready_q))));

  // R7: outside periods 1-2 and the wrap, start cannot change ready
  assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (!in_gate && !wrap_o) |=> (ready_q == $past(ready_q)));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int RES = 12,
  localparam int IW = $clog2(RES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enter_hold_i,
  input  logic           trial_act_i,
  input  logic [IW-1:0]  trial_idx_i,
  input  logic           wrap_i,
  input  logic           cmp_i,
  output logic [RES-1:0] trial_o,
  output logic [RES-1:0] resolved_o
);
  localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] code_q;
  logic [RES-1:0] code_d;

  for (genvar b = 0; b < RES; b++) begin : g_bit
    always_comb begin
      code_d[b] = code_q[b];
      if (wrap_i)            code_d[b] = 1'b0;
      else if (enter_hold_i) code_d[b] = MSB_ONLY[b];
      else if (trial_act_i) begin
        if (int'(trial_idx_i) == b)          code_d[b] = cmp_i;
        else if (int'(trial_idx_i) == b + 1) code_d[b] = 1'b1;
      end
    end

    // R3: the tested bit takes the comparator decision
    if (b > 0) begin : g_chk
      assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (trial_act_i && !wrap_i && (int'(trial_idx_i) == b)) |=> (code_q[b] == $past(cmp_i)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_d;
  end

  assign trial_o    = code_q;
  assign resolved_o = {code_q[RES-1:1], cmp_i};

  // R3: the first trial period shows only the most significant bit
  assert_msb_R3: assert property (@(posedge clk) disable iff (rst)
    enter_hold_i |=> (code_q == MSB_ONLY));
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
  parameter int RES  = 12,
  parameter int LO_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [RES-1:0] code_i,
  input  logic           upper_en_n_i,
  input  logic           lower_en_n_i,
  output logic [RES-1:0] dout_o
);
  logic [RES-1:0] result_q;

  always_ff @(posedge clk) begin
    if (rst)         result_q <= '0;
    else if (load_i) result_q <= code_i;
  end

  for (genvar b = 0; b < RES; b++) begin : g_grp
    if (b >= LO_W) begin : g_up
      assign dout_o[b] = result_q[b] & ~upper_en_n_i;
    end else begin : g_lo
      assign dout_o[b] = result_q[b] & ~lower_en_n_i;
    end
  end

  // R5: the result only moves at a frame end
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(result_q));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int RES   = 12,
  parameter int TRACK = 3,
  parameter int LO_W  = 4,
  parameter int SYNC  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_n,
  input  logic           cmp_hi,
  input  logic           upper_en_n,
  input  logic           lower_en_n,
  output logic           track_o,
  output logic           balance_o,
  output logic [RES-1:0] trial_o,
  output logic           ready_o,
  output logic [RES-1:0] dout_o
);
  localparam int FRAME = TRACK + RES;
  localparam int PW    = $clog2(FRAME + 1);
  localparam int IW    = $clog2(RES);

  logic           start_req;
  logic [PW-1:0]  period;
  logic           trial_act;
  logic [IW-1:0]  trial_idx;
  logic           enter_hold;
  logic           wrap;
  logic           track;
  logic [RES-1:0] resolved;

  sar_start_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .req_n_i(start_n), .req_o(start_req)
  );

  sar_frame_ctl #(.RES(RES), .TRACK(TRACK)) u_ctl (
    .clk(clk), .rst(rst), .start_req_i(start_req),
    .period_o(period), .track_o(track), .trial_act_o(trial_act),
    .trial_idx_o(trial_idx), .enter_hold_o(enter_hold),
    .wrap_o(wrap), .ready_o(ready_o)
  );

  sar_trial_reg #(.RES(RES)) u_trial (
    .clk(clk), .rst(rst), .enter_hold_i(enter_hold), .trial_act_i(trial_act),
    .trial_idx_i(trial_idx), .wrap_i(wrap), .cmp_i(cmp_hi),
    .trial_o(trial_o), .resolved_o(resolved)
  );

  sar_out_stage #(.RES(RES), .LO_W(LO_W)) u_out (
    .clk(clk), .rst(rst), .load_i(wrap), .code_i(resolved),
    .upper_en_n_i(upper_en_n), .lower_en_n_i(lower_en_n), .dout_o(dout_o)
  );

  assign track_o   = track;
  assign balance_o = track;

  // R2: no capacitor is switched to the reference while tracking
  assert_track_clear_R2: assert property (@(posedge clk) disable iff (rst)
    track_o |-> (trial_o == '0));

  // R6: a fresh ready coincides with the return to the tracking phase
  assert_ready_new_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (track_o && (period == PW'(1))));
endmodule

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_n = 1'b1;
  logic        upper_en_n = 1'b0;
  logic        lower_en_n = 1'b0;
  logic [11:0] stim = '0;
  logic        cmp_hi;
  logic        track_o, balance_o, ready_o;
  logic [11:0] trial_o, dout_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  // ideal comparator: input at or above the trial level keeps the bit
  function automatic logic ideal_cmp(input logic [11:0] vin, input logic [11:0] trial);
    return vin >= trial;
  endfunction

  function automatic logic [11:0] exp_mask(input logic [11:0] v, input logic up_n, input logic lo_n);
    logic [11:0] m;
    m = {{8{~up_n}}, {4{~lo_n}}};
    return v & m;
  endfunction

  assign cmp_hi = ideal_cmp(stim, trial_o);

  sar_seq_top dut_i (
    .clk(clk), .rst(rst), .start_n(start_n), .cmp_hi(cmp_hi),
    .upper_en_n(upper_en_n), .lower_en_n(lower_en_n),
    .track_o(track_o), .balance_o(balance_o), .trial_o(trial_o),
    .ready_o(ready_o), .dout_o(dout_o)
  );

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // start-triggered conversion from the parked state
  task automatic single(input logic [11:0] v, input bit mid);
    int trk_low = 0;
    int guard = 0;
    int bad_park = 0;
    logic [11:0] prev = dout_o;
    bit held = 1'b1;
    stim = v;
    start_n = 1'b0;
    tick(); tick(); tick();
    start_n = 1'b1;
    chk(!ready_o && track_o, "R8 start drops ready, still tracking", int'(ready_o), 0);
    while (!ready_o && guard < 60) begin
      tick();
      guard++;
      if (mid) start_n = !(trk_low >= 5 && trk_low < 8);
      if (!track_o) begin
        if (trk_low == 0) chk(trial_o == 12'h800, "R3 first trial code", int'(trial_o), 32'h800);
        if (!balance_o == 1'b0) held = 1'b0;
        trk_low++;
      end
      if (!ready_o && dout_o != prev) held = 1'b0;
    end
    start_n = 1'b1;
    chk(held, "R5 result held during conversion", int'(held), 1);
    chk(guard == 13, "R8 restart to ready latency", guard, 13);
    chk(trk_low == 12, "R2 hold length", trk_low, 12);
    chk(dout_o == v, "R4 single conversion result", int'(dout_o), int'(v));
    for (int k = 0; k < 20; k++) begin
      tick();
      if (!ready_o || !track_o || !balance_o || dout_o != v || trial_o != 0) bad_park++;
    end
    if (mid) chk(bad_park == 0, "R7 mid-frame start ignored", bad_park, 0);
    else     chk(bad_park == 0, "R8 parked with ready high", bad_park, 0);
  endtask

  // one free-running frame; entered at the cycle where ready has just risen
  task automatic run_frame(input logic [11:0] nxt, input logic [11:0] cur);
    int n = 0;
    int rdy_hi = 1;
    int trk_hi = 1;
    int moved = 0;
    logic pr = 1'b1;
    stim = nxt;
    while (n < 40) begin
      tick();
      n++;
      if (ready_o && !pr) break;
      if (ready_o) rdy_hi++;
      if (track_o) trk_hi++;
      if (dout_o != cur) moved++;
      pr = ready_o;
    end
    chk(n == 15, "R1 frame length", n, 15);
    chk(rdy_hi == 1, "R6 ready width in free run", rdy_hi, 1);
    chk(trk_hi == 3, "R2 track periods", trk_hi, 3);
    chk(moved == 0, "R5 result stable in frame", moved, 0);
    chk(dout_o == nxt, "R4 free-run result", int'(dout_o), int'(nxt));
  endtask

  initial begin
    logic [11:0] corner [6];
    logic [11:0] cur;
    int g;
    corner[0] = 12'd0;    corner[1] = 12'd4095; corner[2] = 12'd1;
    corner[3] = 12'd4094; corner[4] = 12'd2048; corner[5] = 12'd2047;
    void'($urandom(32'd5812));

    tick(); tick(); tick();
    chk(track_o && balance_o, "R10 reset tracks", int'(track_o), 1);
    chk(trial_o == 0, "R10 reset trial code", int'(trial_o), 0);
    chk(!ready_o, "R10 reset ready", int'(ready_o), 0);
    chk(dout_o == 0, "R10 reset result", int'(dout_o), 0);
    rst = 1'b0;
    for (int k = 0; k < 10; k++) tick();
    chk(!ready_o && track_o && trial_o == 0, "R8 park after reset", int'(ready_o), 0);

    single(12'd1234, 1'b0);
    single(12'd3001, 1'b1);
    single(12'd4095, 1'b0);

    // free run: start held low
    start_n = 1'b0;
    stim = corner[0];
    g = 0;
    while (!(ready_o == 1'b0) && g < 10) begin tick(); g++; end
    while (!ready_o && g < 40) begin tick(); g++; end
    chk(dout_o == corner[0], "R4 first free-run result", int'(dout_o), int'(corner[0]));
    cur = corner[0];
    for (int i = 1; i < 6; i++) begin
      run_frame(corner[i], cur);
      cur = corner[i];
    end
    for (int i = 0; i < 40; i++) begin
      logic [11:0] r;
      r = 12'($urandom_range(0, 4095));
      run_frame(r, cur);
      cur = r;
    end

    // stop and read the parked result through the group enables
    start_n = 1'b1;
    g = 0;
    while (!(ready_o && track_o && g > 20) && g < 60) begin tick(); g++; end
    chk(dout_o == cur, "R8 parked result kept", int'(dout_o), int'(cur));
    for (int c = 0; c < 4; c++) begin
      upper_en_n = c[1];
      lower_en_n = c[0];
      #1;
      chk(dout_o == exp_mask(cur, c[1], c[0]), "R9 group enables",
          int'(dout_o), int'(exp_mask(cur, c[1], c[0])));
    end
    upper_en_n = 1'b0;
    lower_en_n = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule